// File: doc/BRIEF.md
# Phase-Frequency Comparator with Polarity Select

This block compares two divided pulse trains, a reference train and a feedback train, both synchronous to the block clock. It turns the order of their rising edges into pump requests. The first rising edge seen on one train sets a pending request. The first rising edge on the other train then clears it. The pending request drives three things: a three-state internal pump output, modelled as an output enable plus a level; a pair of outputs for an external pump, one active-low push-pull pulse and one open-drain pull-down enable; and a lock indicator that is high only while no request is pending.

A single polarity-select input has two jobs. It reverses the sense of the comparator and of both pump paths, and it chooses which pulse train is copied to a monitor output. Left high, which is the pulled-up default, the sense is normal and the monitor shows the reference train.

The comparator is a three-state machine. HOLD means no request is pending. LEAD_REF means a reference edge is waiting for a feedback edge. LEAD_FB means a feedback edge is waiting for a reference edge. There are five transitions:
- T_REF_FIRST: HOLD to LEAD_REF, on a reference edge alone.
- T_FB_FIRST: HOLD to LEAD_FB, on a feedback edge alone.
- T_CATCH_FB: LEAD_REF to HOLD, on any feedback edge.
- T_CATCH_REF: LEAD_FB to HOLD, on any reference edge.
- T_SAME_EDGE: HOLD to HOLD, on both edges in the same cycle.

Every other case keeps the current state. A rising edge is detected in the cycle the input is first seen high, and the state register updates on the clock edge that ends that cycle. All pump and lock outputs follow the state combinationally.

Top module: `pfd_phase_cmp`

## Requirements
- R1: `lock_ok` is 1 exactly when no request is pending, and 0 while either request is pending.
- R2: With `pol_sel`=1, a `fr_in` rise seen in HOLD moves the block to LEAD_REF from the next clock edge. In LEAD_REF, `cp_oe`=1 and `cp_level`=1, and this holds until a `fp_in` rise is registered.
- R3: With `pol_sel`=1, a `fp_in` rise seen in HOLD moves the block to LEAD_FB. In LEAD_FB, `cp_oe`=1 and `cp_level`=0, and this holds until a `fr_in` rise is registered.
- R4: With `pol_sel`=0, the pump sense is swapped: LEAD_REF drives `cp_level`=0 and LEAD_FB drives `cp_level`=1. The swap takes effect in the same cycle as the select change.
- R5: Rises on `fr_in` and `fp_in` seen in the same cycle while in HOLD leave the block in HOLD.
- R6: In HOLD, `cp_oe`=0, which stands for high impedance, and `cp_level`=0.
- R7: `ext_up_n` is 0 exactly while `cp_oe`=1 and `cp_level`=1. `ext_dn_pd` is 1 exactly while `cp_oe`=1 and `cp_level`=0. Otherwise `ext_up_n`=1 and `ext_dn_pd`=0.
- R8: `mon_out` equals `fr_in` when `pol_sel`=1 and equals `fp_in` when `pol_sel`=0, with no register delay.
- R9: While `rst`=1 at a clock edge, the state returns to HOLD. An input that is held high across the release of reset is not counted as a rise.
- R10: Further rises of the leading train, seen while its request is pending, change nothing. The first rise of the lagging train clears the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| fr_in | input | 1 | Divided reference pulse train |
| fp_in | input | 1 | Divided feedback pulse train |
| pol_sel | input | 1 | 1 = normal sense and monitor shows fr_in; 0 = reversed sense and monitor shows fp_in |
| cp_oe | output | 1 | Internal pump drive enable (0 = high impedance) |
| cp_level | output | 1 | Internal pump drive level when enabled |
| ext_up_n | output | 1 | External pump pulse, active low |
| ext_dn_pd | output | 1 | External pump open-drain pull-down enable |
| lock_ok | output | 1 | 1 when no phase difference is pending |
| mon_out | output | 1 | Monitor copy of the selected pulse train |

## Verification
The comparator is driven with single reference-first and feedback-first pulse pairs under both polarity settings. These show whether the pump direction depends on which train leads and on the select. Coincident rises separate a detector that cancels simultaneous edges from one that briefly pumps. Bursts of leading-train pulses before a single lagging pulse show whether extra edges are counted or ignored. Holding an input high through reset release, flipping the select while a request is pending, and a long pseudo-random stretch of both trains then test reset edge handling, the immediate polarity swap and the monitor path, all against a step-by-step reference model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    localparam int PULSE_CH  = 2;
    localparam int CH_REF    = 0;
    localparam int CH_FB     = 1;

    typedef enum logic [1:0] {
        ST_HOLD     = 2'b00,
        ST_LEAD_REF = 2'b01,
        ST_LEAD_FB  = 2'b10
    } pfd_state_t;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_ch
        // During reset the history tracks the input, so a level held
        // high across reset release is not mistaken for an edge.
        always_ff @(posedge clk) begin
            prev_q[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q[i] & ~rst;
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rise_ref,
    input  logic      rise_fb,
    output pump_req_t req
);
    pfd_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_HOLD;
        else     state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_HOLD: begin
                if (rise_ref && !rise_fb)      state_nx = ST_LEAD_REF; // T_REF_FIRST
                else if (rise_fb && !rise_ref) state_nx = ST_LEAD_FB;  // T_FB_FIRST
                else                           state_nx = ST_HOLD;     // T_SAME_EDGE or idle
            end
            ST_LEAD_REF: if (rise_fb)  state_nx = ST_HOLD;             // T_CATCH_FB
            ST_LEAD_FB:  if (rise_ref) state_nx = ST_HOLD;             // T_CATCH_REF
            default:                   state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        req = '0;
        unique case (state_q)
            ST_HOLD:     req = '0;
            ST_LEAD_REF: req.up = 1'b1;
            ST_LEAD_FB:  req.dn = 1'b1;
            default:     req = '0;
        endcase
    end

endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
    import pfd_pkg::*;
(
    input  pump_req_t req,
    input  logic      pol_sel,
    input  logic      fr_in,
    input  logic      fp_in,
    output logic      cp_oe,
    output logic      cp_level,
    output logic      ext_up_n,
    output logic      ext_dn_pd,
    output logic      lock_ok,
    output logic      mon_out
);
    logic eff_up, eff_dn;

    always_comb begin
        eff_up    = pol_sel ? req.up : req.dn;
        eff_dn    = pol_sel ? req.dn : req.up;
        cp_oe     = req.up | req.dn;
        cp_level  = eff_up;
        ext_up_n  = ~eff_up;
        ext_dn_pd = eff_dn;
        lock_ok   = ~(req.up | req.dn);
        mon_out   = pol_sel ? fr_in : fp_in;
    end

endmodule

// File: rtl/pfd_phase_cmp.sv
module pfd_phase_cmp
    import pfd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fr_in,
    input  logic fp_in,
    input  logic pol_sel,
    output logic cp_oe,
    output logic cp_level,
    output logic ext_up_n,
    output logic ext_dn_pd,
    output logic lock_ok,
    output logic mon_out
);
    logic [PULSE_CH-1:0] pulses, rises;
    pump_req_t           req;

    assign pulses[CH_REF] = fr_in;
    assign pulses[CH_FB]  = fp_in;

    pfd_edge_det #(.N(PULSE_CH)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  (pulses),
        .rise (rises)
    );

    pfd_core u_core (
        .clk      (clk),
        .rst      (rst),
        .rise_ref (rises[CH_REF]),
        .rise_fb  (rises[CH_FB]),
        .req      (req)
    );

    pfd_out_map u_map (
        .req       (req),
        .pol_sel   (pol_sel),
        .fr_in     (fr_in),
        .fp_in     (fp_in),
        .cp_oe     (cp_oe),
        .cp_level  (cp_level),
        .ext_up_n  (ext_up_n),
        .ext_dn_pd (ext_dn_pd),
        .lock_ok   (lock_ok),
        .mon_out   (mon_out)
    );

endmodule

// File: rtl/pfd_phase_cmp_chk.sv
module pfd_phase_cmp_chk (
    input logic clk,
    input logic rst,
    input logic fr_in,
    input logic fp_in,
    input logic pol_sel,
    input logic cp_oe,
    input logic cp_level,
    input logic ext_up_n,
    input logic ext_dn_pd,
    input logic lock_ok,
    input logic mon_out
);
    assert_lock_vs_pump_R1: assert property (@(posedge clk) disable iff (rst)
        lock_ok == !cp_oe);

    // R2 and R4: a lone reference edge from HOLD drives the level given by the select
    assert_ref_lead_sense_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(fr_in) && !$rose(fp_in) && lock_ok) |=> (cp_oe && (cp_level == pol_sel)));

    // R3 and R4: a lone feedback edge from HOLD drives the opposite level
    assert_fb_lead_sense_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(fp_in) && !$rose(fr_in) && lock_ok) |=> (cp_oe && (cp_level == !pol_sel)));

    assert_same_edge_idle_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(fr_in) && $rose(fp_in) && lock_ok) |=> lock_ok);

    assert_ext_active_R7: assert property (@(posedge clk) disable iff (rst)
        cp_oe |-> ((ext_up_n == !cp_level) && (ext_dn_pd == !cp_level)));

    assert_ext_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !cp_oe |-> (ext_up_n && !ext_dn_pd));

    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lock_ok && !cp_oe));

    // R10: a pending request survives a cycle without a lagging edge
    assert_pending_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!lock_ok && !$rose(fr_in) && !$rose(fp_in)) |=> !lock_ok);

endmodule

bind pfd_phase_cmp pfd_phase_cmp_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .fr_in     (fr_in),
    .fp_in     (fp_in),
    .pol_sel   (pol_sel),
    .cp_oe     (cp_oe),
    .cp_level  (cp_level),
    .ext_up_n  (ext_up_n),
    .ext_dn_pd (ext_dn_pd),
    .lock_ok   (lock_ok),
    .mon_out   (mon_out)
);

// File: tb/sim_pfd_phase_cmp.sv
`timescale 1ns/1ps
module sim_pfd_phase_cmp;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr_in = 1'b0, fp_in = 1'b0, pol_sel = 1'b1;
    logic cp_oe, cp_level, ext_up_n, ext_dn_pd, lock_ok, mon_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    string cur_req = "R6";

    always #10 clk = ~clk;

    pfd_phase_cmp u0 (
        .clk(clk), .rst(rst), .fr_in(fr_in), .fp_in(fp_in), .pol_sel(pol_sel),
        .cp_oe(cp_oe), .cp_level(cp_level), .ext_up_n(ext_up_n),
        .ext_dn_pd(ext_dn_pd), .lock_ok(lock_ok), .mon_out(mon_out)
    );

    // Behavioural reference: two request bits and last-seen input levels
    int m_up = 0, m_dn = 0, m_prev_fr = 0, m_prev_fp = 0;

    always @(posedge clk) begin
        int r, p, nu, nd;
        if (rst) begin
            m_up = 0; m_dn = 0;
        end else begin
            r  = (fr_in && !m_prev_fr) ? 1 : 0;
            p  = (fp_in && !m_prev_fp) ? 1 : 0;
            nu = (m_up || r) ? 1 : 0;
            nd = (m_dn || p) ? 1 : 0;
            if (nu && nd) begin nu = 0; nd = 0; end
            m_up = nu; m_dn = nd;
        end
        m_prev_fr = fr_in;
        m_prev_fp = fp_in;
    end

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic e_up, e_dn;
        if (!done && !rst) begin
            e_up = pol_sel ? (m_up != 0) : (m_dn != 0);
            e_dn = pol_sel ? (m_dn != 0) : (m_up != 0);
            chk("R1", "lock_ok", lock_ok, !(m_up || m_dn));
            chk(cur_req, "cp_oe", cp_oe, (m_up || m_dn));
            chk(cur_req, "cp_level", cp_level, e_up);
            chk("R7", "ext_up_n", ext_up_n, !e_up);
            chk("R7", "ext_dn_pd", ext_dn_pd, e_dn);
            chk("R8", "mon_out", mon_out, pol_sel ? fr_in : fp_in);
        end
    end

    task automatic step(input logic f, input logic p, input logic s);
        @(posedge clk);
        #4;
        fr_in = f; fp_in = p; pol_sel = s;
    endtask

    task automatic idle(input int n, input logic s);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, s);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lfsr;
        // R9: fr held high through reset release must not count as an edge
        fr_in = 1'b1;
        repeat (4) @(posedge clk);
        #4 rst = 1'b0;
        @(negedge clk);
        cur_req = "R9";
        chk("R9", "lock_ok after reset", lock_ok, 1'b1);
        chk("R9", "cp_oe after reset", cp_oe, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R9", "held level no edge", lock_ok, 1'b1);

        cur_req = "R6";
        idle(3, 1'b1);
        @(negedge clk);
        chk("R6", "cp_oe idle", cp_oe, 1'b0);
        chk("R6", "cp_level idle", cp_level, 1'b0);

        // R2: reference leads, normal sense
        cur_req = "R2";
        step(1'b1, 1'b0, 1'b1); step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R2", "pump high after ref edge", cp_level & cp_oe, 1'b1);
        idle(2, 1'b1);
        step(1'b0, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R2", "cleared by fb edge", cp_oe, 1'b0);

        // R3: feedback leads, normal sense
        cur_req = "R3";
        step(1'b0, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R3", "pump low after fb edge", cp_oe & !cp_level, 1'b1);
        step(1'b1, 1'b0, 1'b1); idle(2, 1'b1);

        // R4: reversed sense, both orders, and a mid-request flip
        cur_req = "R4";
        step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R4", "ref lead reversed", cp_oe & !cp_level, 1'b1);
        step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R4", "flip select while pending", cp_level, 1'b1);
        step(1'b0, 1'b1, 1'b0); idle(2, 1'b0);
        step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R4", "fb lead reversed", cp_oe & cp_level, 1'b1);
        step(1'b1, 1'b0, 1'b0); idle(2, 1'b1);

        // R5: coincident edges
        cur_req = "R5";
        step(1'b1, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R5", "same edge stays idle", lock_ok, 1'b1);
        idle(2, 1'b1);

        // R10: burst of leading edges, one lagging edge clears
        cur_req = "R10";
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 1'b1); step(1'b0, 1'b0, 1'b1);
        end
        @(negedge clk);
        chk("R10", "still pending after burst", lock_ok, 1'b0);
        step(1'b0, 1'b1, 1'b1); step(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10", "one lagging edge clears", lock_ok, 1'b1);

        // R8 and mixed traffic: pseudo-random trains and select
        cur_req = "R4";
        lfsr = 32'h1ace5;
        for (int k = 0; k < 600; k++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
            step(lfsr[3] & lfsr[7], lfsr[11] & lfsr[13], (k % 97) < 60);
        end

        // R9: mid-run reset with a request pending
        step(1'b1, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
        @(posedge clk); #4 rst = 1'b1;
        @(posedge clk); #4 rst = 1'b0;
        @(negedge clk);
        chk("R9", "reset clears pending", lock_ok, 1'b1);
        idle(2, 1'b1);
        @(negedge clk);
        finish_run();
    end
endmodule